// File: doc/BRIEF.md
# Three-Stage Instruction Control Decoder

This block is the control unit of a small 4-bit processor that spends three clock cycles on every instruction. A built-in stage counter steps through fetch, register-read/execute and write-back. In each stage the block decodes the 4-bit opcode, which is the top nibble of the current instruction, and drives one set of datapath control lines for that stage. The opcode is meant to stay stable for the whole instruction.

The control lines do the following:

- Strobe an instruction fetch.
- Read or write the data memory.
- Read or write the register file.
- Take a branch.
- Load the memory-address register, from a register or from the immediate.
- Steer the result to the implicit register 3.
- Select an immediate operand or a shift amount as the second ALU input.
- Write a literal nibble or a zero into the register file.

A 3-bit ALU function select goes with these lines. The one exception to per-stage decoding is the branch condition select. It comes straight from the opcode and holds for the whole instruction.

Top module: `stage_ctrl_unit`

## Requirements
- R1: While `rst_n` is low, every control output and `alu_op` is 0, and `stage` is 0 (fetch). `br_on_zero` is also 0.
- R2: After reset, `stage` advances once per clock in the order 0 (fetch), 1 (execute), 2 (write-back), then back to 0.
- R3: In fetch, for every opcode, `inst_fetch` and `mem_rd` are 1 and all other lines except `br_on_zero` are 0.
- R4: The ALU opcodes are ADD=3, SUB=4, NOT=5, AND=6 and OR=7. Each asserts only `rf_rd` in execute and only `rf_wr` in write-back. In execute, `alu_op` is add=0, sub=1, and=2, or=3, not=4 or shift=5. `alu_op` is 0 in every other stage and for every opcode that is not an ALU opcode.
- R5: SLL (opcode 2) asserts `rf_rd` and `alu_b_imm` in execute, with `alu_op`=5. It asserts only `rf_wr` in write-back.
- R6: BEZ (opcode 0) and BGZ (opcode 1) assert `rf_rd` and `branch` in execute. They assert nothing in write-back.
- R7: Outside reset, `br_on_zero` is 1 exactly when the opcode is 0 (BEZ), in all three stages.
- R8: LW (opcode 8) asserts only `mem_rd` in execute and only `rf_wr` in write-back. SW (opcode 9) asserts `rf_rd` and `mem_wr` in execute and nothing in write-back.
- R9: SETM (opcode 10) asserts `rf_rd`, `addr_reg_ld` and `addr_src_reg` in execute. SETMI (opcode 11) asserts only `addr_reg_ld` in execute. Neither asserts anything in write-back.
- R10: ADDI (opcode 12) asserts `rf_rd`, `dst_r3`, `imm_nibble` and `alu_b_imm` in execute, with `alu_op`=0. It asserts only `rf_wr` in write-back.
- R11: LDI (opcode 13) asserts nothing in execute and asserts `rf_wr`, `dst_r3` and `wb_imm` in write-back. ZERO (opcode 14) asserts nothing in execute and asserts `rf_wr` and `wb_zero` in write-back.
- R12: Opcode 15 is a no-op that asserts nothing in execute or write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 4 | Top nibble of the current instruction |
| stage | output | 2 | Current stage: 0 fetch, 1 execute, 2 write-back |
| inst_fetch | output | 1 | Instruction fetch strobe |
| mem_rd | output | 1 | Memory read enable |
| mem_wr | output | 1 | Data memory write enable |
| rf_rd | output | 1 | Register file read enable |
| rf_wr | output | 1 | Register file write enable |
| branch | output | 1 | Branch evaluation enable |
| br_on_zero | output | 1 | Branch condition: 1 tests equal-to-zero, 0 tests greater-than-zero |
| alu_b_imm | output | 1 | ALU second operand from the immediate or shift field |
| addr_reg_ld | output | 1 | Load the memory-address register |
| addr_src_reg | output | 1 | Address register source is a register, not the immediate |
| dst_r3 | output | 1 | Use implicit register 3 |
| imm_nibble | output | 1 | Use the low nibble as a 4-bit immediate |
| wb_imm | output | 1 | Write-back data is the immediate |
| wb_zero | output | 1 | Write-back data is zero |
| alu_op | output | 3 | ALU function select |

## Verification
The bench drives each of the 16 opcodes through a full three-stage pass and compares the whole output vector at every stage. A stage counter that skips, sticks or fails to wrap puts the wrong stage set on the outputs at the very next clock. Because each stage has its own fixed pattern, such a fault shows within one cycle. A decode fault for one opcode and stage shows only while that pair is present, so every pair is visited. Resets before the first instruction and in the middle of one confirm that the outputs go quiet at once and that the sequence restarts at fetch.

// File: rtl/stage_ctrl_pkg.sv
package stage_ctrl_pkg;

    localparam int OPC_W = 4;
    localparam int STG_W = 2;
    localparam int ALU_W = 3;

    typedef enum logic [STG_W-1:0] {
        STG_FETCH = 2'd0,
        STG_EXEC  = 2'd1,
        STG_WB    = 2'd2
    } stage_e;

    typedef enum logic [OPC_W-1:0] {
        OP_BEZ   = 4'd0,
        OP_BGZ   = 4'd1,
        OP_SLL   = 4'd2,
        OP_ADD   = 4'd3,
        OP_SUB   = 4'd4,
        OP_NOT   = 4'd5,
        OP_AND   = 4'd6,
        OP_OR    = 4'd7,
        OP_LW    = 4'd8,
        OP_SW    = 4'd9,
        OP_SETM  = 4'd10,
        OP_SETMI = 4'd11,
        OP_ADDI  = 4'd12,
        OP_LDI   = 4'd13,
        OP_ZERO  = 4'd14,
        OP_NOP   = 4'd15
    } opc_e;

    typedef enum logic [ALU_W-1:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_AND = 3'd2,
        ALU_OR  = 3'd3,
        ALU_NOT = 3'd4,
        ALU_SLL = 3'd5
    } alu_e;

    typedef struct packed {
        logic inst_fetch;
        logic mem_rd;
        logic mem_wr;
        logic rf_rd;
        logic rf_wr;
        logic branch;
        logic br_on_zero;
        logic alu_b_imm;
        logic addr_reg_ld;
        logic addr_src_reg;
        logic dst_r3;
        logic imm_nibble;
        logic wb_imm;
        logic wb_zero;
        alu_e alu_op;
    } ctrl_t;

endpackage

// File: rtl/stage_ctrl_seq.sv
module stage_ctrl_seq
    import stage_ctrl_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output stage_e stage_q
);

    typedef struct packed {
        stage_e stage;
    } seq_t;

    seq_t seq_d;
    seq_t seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.stage)
            STG_FETCH: seq_d.stage = STG_EXEC;
            STG_EXEC:  seq_d.stage = STG_WB;
            STG_WB:    seq_d.stage = STG_FETCH;
            default:   seq_d.stage = STG_FETCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.stage <= STG_FETCH;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign stage_q = seq_q.stage;

    p_stage_f2e_r2: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.stage == STG_FETCH |=> seq_q.stage == STG_EXEC);
    p_stage_e2w_r2: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.stage == STG_EXEC |=> seq_q.stage == STG_WB);
    p_stage_w2f_r2: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.stage == STG_WB |=> seq_q.stage == STG_FETCH);

endmodule

// File: rtl/stage_ctrl_dec.sv
module stage_ctrl_dec
    import stage_ctrl_pkg::*;
(
    input  stage_e           stage,
    input  logic [OPC_W-1:0] opcode,
    output ctrl_t            ctrl_d
);

    opc_e opc;
    assign opc = opc_e'(opcode);

    always_comb begin
        ctrl_d = '0;
        ctrl_d.alu_op = ALU_ADD;
        // condition select follows the opcode for the whole instruction
        ctrl_d.br_on_zero = (opc == OP_BEZ);

        unique case (stage)
            STG_FETCH: begin
                ctrl_d.inst_fetch = 1'b1;
                ctrl_d.mem_rd     = 1'b1;
            end

            STG_EXEC: begin
                case (opc)
                    OP_BEZ, OP_BGZ: begin
                        ctrl_d.rf_rd  = 1'b1;
                        ctrl_d.branch = 1'b1;
                    end
                    OP_SLL: begin
                        ctrl_d.rf_rd     = 1'b1;
                        ctrl_d.alu_b_imm = 1'b1;
                        ctrl_d.alu_op    = ALU_SLL;
                    end
                    OP_ADD: begin
                        ctrl_d.rf_rd  = 1'b1;
                        ctrl_d.alu_op = ALU_ADD;
                    end
                    OP_SUB: begin
                        ctrl_d.rf_rd  = 1'b1;
                        ctrl_d.alu_op = ALU_SUB;
                    end
                    OP_NOT: begin
                        ctrl_d.rf_rd  = 1'b1;
                        ctrl_d.alu_op = ALU_NOT;
                    end
                    OP_AND: begin
                        ctrl_d.rf_rd  = 1'b1;
                        ctrl_d.alu_op = ALU_AND;
                    end
                    OP_OR: begin
                        ctrl_d.rf_rd  = 1'b1;
                        ctrl_d.alu_op = ALU_OR;
                    end
                    OP_LW: begin
                        ctrl_d.mem_rd = 1'b1;
                    end
                    OP_SW: begin
                        ctrl_d.rf_rd  = 1'b1;
                        ctrl_d.mem_wr = 1'b1;
                    end
                    OP_SETM: begin
                        ctrl_d.rf_rd        = 1'b1;
                        ctrl_d.addr_reg_ld  = 1'b1;
                        ctrl_d.addr_src_reg = 1'b1;
                    end
                    OP_SETMI: begin
                        ctrl_d.addr_reg_ld = 1'b1;
                    end
                    OP_ADDI: begin
                        ctrl_d.rf_rd      = 1'b1;
                        ctrl_d.dst_r3     = 1'b1;
                        ctrl_d.imm_nibble = 1'b1;
                        ctrl_d.alu_b_imm  = 1'b1;
                        ctrl_d.alu_op     = ALU_ADD;
                    end
                    default: ;
                endcase
            end

            STG_WB: begin
                case (opc)
                    OP_SLL, OP_ADD, OP_SUB, OP_NOT, OP_AND, OP_OR,
                    OP_LW, OP_ADDI: begin
                        ctrl_d.rf_wr = 1'b1;
                    end
                    OP_LDI: begin
                        ctrl_d.rf_wr  = 1'b1;
                        ctrl_d.dst_r3 = 1'b1;
                        ctrl_d.wb_imm = 1'b1;
                    end
                    OP_ZERO: begin
                        ctrl_d.rf_wr   = 1'b1;
                        ctrl_d.wb_zero = 1'b1;
                    end
                    default: ;
                endcase
            end

            default: ;
        endcase
    end

endmodule

// File: rtl/stage_ctrl_unit.sv
module stage_ctrl_unit
    import stage_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPC_W-1:0] opcode,
    output logic [STG_W-1:0] stage,
    output logic             inst_fetch,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             rf_rd,
    output logic             rf_wr,
    output logic             branch,
    output logic             br_on_zero,
    output logic             alu_b_imm,
    output logic             addr_reg_ld,
    output logic             addr_src_reg,
    output logic             dst_r3,
    output logic             imm_nibble,
    output logic             wb_imm,
    output logic             wb_zero,
    output logic [ALU_W-1:0] alu_op
);

    stage_e stage_q;
    ctrl_t  ctrl_raw;
    ctrl_t  ctrl_o;

    stage_ctrl_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .stage_q (stage_q)
    );

    stage_ctrl_dec u_dec (
        .stage  (stage_q),
        .opcode (opcode),
        .ctrl_d (ctrl_raw)
    );

    // reset silences every line, including the opcode-driven condition select
    assign ctrl_o = rst_n ? ctrl_raw : '0;

    assign stage        = stage_q;
    assign inst_fetch   = ctrl_o.inst_fetch;
    assign mem_rd       = ctrl_o.mem_rd;
    assign mem_wr       = ctrl_o.mem_wr;
    assign rf_rd        = ctrl_o.rf_rd;
    assign rf_wr        = ctrl_o.rf_wr;
    assign branch       = ctrl_o.branch;
    assign br_on_zero   = ctrl_o.br_on_zero;
    assign alu_b_imm    = ctrl_o.alu_b_imm;
    assign addr_reg_ld  = ctrl_o.addr_reg_ld;
    assign addr_src_reg = ctrl_o.addr_src_reg;
    assign dst_r3       = ctrl_o.dst_r3;
    assign imm_nibble   = ctrl_o.imm_nibble;
    assign wb_imm       = ctrl_o.wb_imm;
    assign wb_zero      = ctrl_o.wb_zero;
    assign alu_op       = ctrl_o.alu_op;

    // R1: quiet outputs during reset
    always_comb begin
        if (!rst_n) begin
            p_reset_quiet_r1: assert (ctrl_o == '0);
        end
    end

    p_fetch_lines_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stage_q == STG_FETCH |-> inst_fetch && mem_rd && !rf_wr && !mem_wr && !rf_rd);
    p_branch_exec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        branch |-> rf_rd && stage_q == STG_EXEC);
    p_wb_no_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stage_q == STG_WB |-> !mem_wr && !rf_rd && !addr_reg_ld);
    p_r3_use_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dst_r3 |-> (stage_q == STG_WB && rf_wr) || (stage_q == STG_EXEC && imm_nibble));
    p_wb_src_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wb_zero |-> !wb_imm && rf_wr && stage_q == STG_WB);
    p_nop_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        opcode == 4'd15 && stage_q != STG_FETCH |-> !rf_wr && !rf_rd && !mem_rd);

endmodule

// File: tb/stage_ctrl_unit_tb_top.sv
`timescale 1ns/1ps
module stage_ctrl_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] opcode = 4'd0;
    logic [1:0] stage;
    logic       inst_fetch, mem_rd, mem_wr, rf_rd, rf_wr, branch, br_on_zero;
    logic       alu_b_imm, addr_reg_ld, addr_src_reg, dst_r3, imm_nibble;
    logic       wb_imm, wb_zero;
    logic [2:0] alu_op;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    stage_ctrl_unit dut_i (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .stage(stage),
        .inst_fetch(inst_fetch), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .rf_rd(rf_rd), .rf_wr(rf_wr), .branch(branch), .br_on_zero(br_on_zero),
        .alu_b_imm(alu_b_imm), .addr_reg_ld(addr_reg_ld), .addr_src_reg(addr_src_reg),
        .dst_r3(dst_r3), .imm_nibble(imm_nibble), .wb_imm(wb_imm),
        .wb_zero(wb_zero), .alu_op(alu_op)
    );

    localparam logic [13:0] M_IF   = 14'b1 << 13;
    localparam logic [13:0] M_MRD  = 14'b1 << 12;
    localparam logic [13:0] M_MWR  = 14'b1 << 11;
    localparam logic [13:0] M_RRD  = 14'b1 << 10;
    localparam logic [13:0] M_RWR  = 14'b1 << 9;
    localparam logic [13:0] M_BR   = 14'b1 << 8;
    localparam logic [13:0] M_BZ   = 14'b1 << 7;
    localparam logic [13:0] M_AB   = 14'b1 << 6;
    localparam logic [13:0] M_ALD  = 14'b1 << 5;
    localparam logic [13:0] M_ASRC = 14'b1 << 4;
    localparam logic [13:0] M_R3   = 14'b1 << 3;
    localparam logic [13:0] M_IMM  = 14'b1 << 2;
    localparam logic [13:0] M_WIMM = 14'b1 << 1;
    localparam logic [13:0] M_WZ   = 14'b1;

    function automatic logic [18:0] observe();
        return {stage, alu_op, inst_fetch, mem_rd, mem_wr, rf_rd, rf_wr, branch,
                br_on_zero, alu_b_imm, addr_reg_ld, addr_src_reg, dst_r3,
                imm_nibble, wb_imm, wb_zero};
    endfunction

    task automatic check(input string req, input logic [18:0] exp);
        logic [18:0] act;
        act = observe();
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: act=%h exp=%h (stage/alu/lines)", req, act, exp);
        end
    endtask

    // Entered at a falling edge with stage at fetch; leaves at the next fetch.
    task automatic run_instr(input string req, input logic [3:0] op,
                             input logic [13:0] e_vec, input logic [2:0] e_alu,
                             input logic [13:0] w_vec);
        logic [13:0] bz;
        bz = (op == 4'd0) ? M_BZ : 14'd0;
        opcode = op;
        #1;
        check({req, " fetch R3"}, {2'd0, 3'd0, M_IF | M_MRD | bz});
        @(negedge clk);
        check({req, " exec"}, {2'd1, e_alu, e_vec | bz});
        @(negedge clk);
        check({req, " wb"}, {2'd2, 3'd0, w_vec | bz});
        @(negedge clk);
    endtask

    task automatic t_reset_r1();
        opcode = 4'd0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 in reset", 19'd0);
        rst_n = 1'b1;
        #1;
        check("R1 after release R7", {2'd0, 3'd0, M_IF | M_MRD | M_BZ});
    endtask

    task automatic t_sequence_r2();
        opcode = 4'd15;
        for (int i = 0; i < 6; i++) begin
            #1;
            total++;
            if (stage !== 2'(i % 3)) begin
                bad++;
                $display("FAIL R2: stage act=%0d exp=%0d", stage, i % 3);
            end
            @(negedge clk);
        end
    endtask

    task automatic t_alu_r4();
        run_instr("R4 ADD", 4'd3, M_RRD, 3'd0, M_RWR);
        run_instr("R4 SUB", 4'd4, M_RRD, 3'd1, M_RWR);
        run_instr("R4 NOT", 4'd5, M_RRD, 3'd4, M_RWR);
        run_instr("R4 AND", 4'd6, M_RRD, 3'd2, M_RWR);
        run_instr("R4 OR",  4'd7, M_RRD, 3'd3, M_RWR);
    endtask

    task automatic t_shift_r5();
        run_instr("R5 SLL", 4'd2, M_RRD | M_AB, 3'd5, M_RWR);
    endtask

    task automatic t_branch_r6_r7();
        run_instr("R6 R7 BEZ", 4'd0, M_RRD | M_BR, 3'd0, 14'd0);
        run_instr("R6 R7 BGZ", 4'd1, M_RRD | M_BR, 3'd0, 14'd0);
    endtask

    task automatic t_mem_r8();
        run_instr("R8 LW", 4'd8, M_MRD, 3'd0, M_RWR);
        run_instr("R8 SW", 4'd9, M_RRD | M_MWR, 3'd0, 14'd0);
    endtask

    task automatic t_addr_r9();
        run_instr("R9 SETM",  4'd10, M_RRD | M_ALD | M_ASRC, 3'd0, 14'd0);
        run_instr("R9 SETMI", 4'd11, M_ALD, 3'd0, 14'd0);
    endtask

    task automatic t_addi_r10();
        run_instr("R10 ADDI", 4'd12, M_RRD | M_R3 | M_IMM | M_AB, 3'd0, M_RWR);
    endtask

    task automatic t_wbsrc_r11();
        run_instr("R11 LDI",  4'd13, 14'd0, 3'd0, M_RWR | M_R3 | M_WIMM);
        run_instr("R11 ZERO", 4'd14, 14'd0, 3'd0, M_RWR | M_WZ);
    endtask

    task automatic t_nop_r12();
        run_instr("R12 NOP", 4'd15, 14'd0, 3'd0, 14'd0);
    endtask

    task automatic t_midreset_r1();
        opcode = 4'd3;
        @(negedge clk);
        #1;
        rst_n = 1'b0;
        #1;
        check("R1 mid-instruction reset", 19'd0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 restart at fetch R2", {2'd0, 3'd0, M_IF | M_MRD});
        @(negedge clk);
        check("R1 R4 restart exec", {2'd1, 3'd0, M_RRD});
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        bad++;
        total++;
        $display("FAIL watchdog: act=timeout exp=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset_r1();
        t_sequence_r2();
        t_alu_r4();
        t_shift_r5();
        t_branch_r6_r7();
        t_mem_r8();
        t_addr_r9();
        t_addi_r10();
        t_wbsrc_r11();
        t_nop_r12();
        t_midreset_r1();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule